// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken by comparing two register operands under a 3-bit function code. Six conditions are supported: equal, not equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. All of them come from one subtraction. That subtraction yields a zero indication, a borrow, the sign of the difference and a signed-overflow indication, and the selected condition is built from these.

The signed ordering does not rely on the sign of the difference alone. It takes that sign XORed with overflow, and overflow is the XOR of the carry into the most significant bit and the carry out of it. Next to the subtractor, a separate equality signal is formed by reducing the bitwise XOR of the operands, which needs no carry chain.

One register stage samples the operands when `in_valid` is high. The branch decision, an illegal-code flag, the four flags and the XOR equality signal appear one clock later together with `out_valid`. A synchronous reset clears all outputs.

Top module: `brcond_unit`

## Requirements
- R1: Code 000 (equal) is taken exactly when `op_a - op_b` is zero. Code 001 (not equal) is taken exactly when it is non-zero. `flag_zero` reports the zero result.
- R2: `eq_xor` is 1 exactly when every bit of `op_a ^ op_b` is zero. It always agrees with `flag_zero`.
- R3: `flag_ovf` is the carry into the MSB of the subtraction XOR the carry out of it. `flag_sign` is the MSB of the difference. Code 100 (signed less-than) is taken exactly when `flag_sign ^ flag_ovf` is 1.
- R4: `flag_borrow` is 1 exactly when `op_a` is below `op_b` as unsigned numbers (1 minus 2 gives 1). Code 110 (unsigned less-than) is taken when the borrow is 1. Code 111 (unsigned greater-or-equal) is taken when the borrow is 0.
- R5: Code 101 (signed greater-or-equal) is taken exactly when `flag_sign` equals `flag_ovf`.
- R6: `flag_sign ^ flag_ovf` equals bit 32 of the difference of both operands sign-extended to 33 bits.
- R7: With `op_a` = 0x80000000 and `op_b` = 0x7FFFFFFF, signed less-than is taken even though `flag_sign` is 0.
- R8: Codes 010 and 011 give `taken` = 0 and `illegal` = 1. All other codes give `illegal` = 0.
- R9: Inputs are sampled on a clock edge where `in_valid` is 1. Results and `out_valid` = 1 appear after that edge. After an edge with `in_valid` = 0, `out_valid` is 0 and the other outputs keep their last values.
- R10: A synchronous reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and function code are valid this cycle |
| op_a | input | 32 | First operand (minuend) |
| op_b | input | 32 | Second operand (subtrahend) |
| func | input | 3 | Branch function code |
| out_valid | output | 1 | Registered results are new this cycle |
| taken | output | 1 | Branch decision |
| illegal | output | 1 | Function code was 010 or 011 |
| flag_zero | output | 1 | Difference was zero |
| flag_borrow | output | 1 | Unsigned borrow out of the subtraction |
| flag_sign | output | 1 | MSB of the difference |
| flag_ovf | output | 1 | Signed overflow of the subtraction |
| eq_xor | output | 1 | Equality from the XOR reduction |

## Verification
On every cycle, the assertions check several relations. The XOR equality must agree with the zero flag. Each function code must pick the right flag combination. The signed ordering must match an independent 33-bit sign-extended subtraction, and the valid strobe must follow the input strobe by one edge. Only the bench scenarios can show the rest. These cover the numerical correctness of the flags against reference signed and unsigned comparisons, the minimum-versus-maximum corner, holding of outputs while idle, and the cleared state after a mid-run reset.

// File: rtl/brcond_unit.sv
module brcond_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   func,
  output logic         out_valid,
  output logic         taken,
  output logic         illegal,
  output logic         flag_zero,
  output logic         flag_borrow,
  output logic         flag_sign,
  output logic         flag_ovf,
  output logic         eq_xor
);

  logic [W:0]   full_sum;
  logic [W-1:0] low_sum;
  logic [W-1:0] diff;
  logic         c_msb_in, c_msb_out;
  logic         z, eqx, brw, sgn, ovf, slt;
  logic         dec, ill;

  // a - b as a + ~b + 1; the low sum exposes the carry entering the MSB
  assign full_sum  = {1'b0, op_a} + {1'b0, ~op_b} + {{W{1'b0}}, 1'b1};
  assign low_sum   = {1'b0, op_a[W-2:0]} + {1'b0, ~op_b[W-2:0]} + {{(W-1){1'b0}}, 1'b1};
  assign diff      = full_sum[W-1:0];
  assign c_msb_out = full_sum[W];
  assign c_msb_in  = low_sum[W-1];

  assign z   = ~|diff;
  assign eqx = ~|(op_a ^ op_b);
  assign brw = ~c_msb_out;
  assign sgn = diff[W-1];
  assign ovf = c_msb_in ^ c_msb_out;
  assign slt = sgn ^ ovf;

  always_comb begin
    ill = 1'b0;
    case (func)
      3'b000:  dec = z;
      3'b001:  dec = ~z;
      3'b100:  dec = slt;
      3'b101:  dec = ~slt;
      3'b110:  dec = brw;
      3'b111:  dec = ~brw;
      default: begin
        dec = 1'b0;
        ill = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      taken       <= 1'b0;
      illegal     <= 1'b0;
      flag_zero   <= 1'b0;
      flag_borrow <= 1'b0;
      flag_sign   <= 1'b0;
      flag_ovf    <= 1'b0;
      eq_xor      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken       <= dec;
        illegal     <= ill;
        flag_zero   <= z;
        flag_borrow <= brw;
        flag_sign   <= sgn;
        flag_ovf    <= ovf;
        eq_xor      <= eqx;
      end
    end
  end

endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   func,
  input logic         out_valid,
  input logic         taken,
  input logic         illegal,
  input logic         flag_zero,
  input logic         flag_borrow,
  input logic         flag_sign,
  input logic         flag_ovf,
  input logic         eq_xor
);

  logic [W:0] wide_diff;
  assign wide_diff = {op_a[W-1], op_a} - {op_b[W-1], op_b};

  p_eq_zero_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) == 3'b000) |-> (taken == flag_zero));

  p_xor_match_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (eq_xor == flag_zero));

  p_slt_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) == 3'b100) |-> (taken == (flag_sign ^ flag_ovf)));

  p_ltu_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) == 3'b110) |-> (taken == flag_borrow));

  p_sge_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid) && $past(func) == 3'b101) |-> (taken == (flag_sign == flag_ovf)));

  p_wide_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((flag_sign ^ flag_ovf) == $past(wide_diff[W])));

  p_illegal_r8: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !taken);

  p_valid_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(taken)));

endmodule

bind brcond_unit brcond_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .func(func), .out_valid(out_valid), .taken(taken), .illegal(illegal),
  .flag_zero(flag_zero), .flag_borrow(flag_borrow), .flag_sign(flag_sign),
  .flag_ovf(flag_ovf), .eq_xor(eq_xor)
);

// File: tb/brcond_unit_test.sv
`timescale 1ns/1ps
module brcond_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [2:0]  func = '0;
  logic out_valid, taken, illegal, flag_zero, flag_borrow, flag_sign, flag_ovf, eq_xor;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brcond_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .func(func), .out_valid(out_valid), .taken(taken), .illegal(illegal),
    .flag_zero(flag_zero), .flag_borrow(flag_borrow), .flag_sign(flag_sign),
    .flag_ovf(flag_ovf), .eq_xor(eq_xor)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b (a=%h b=%h f=%b)", req, act, exp, op_a, op_b, func);
    end
  endtask

  function automatic logic ref_taken(logic [31:0] a, logic [31:0] b, logic [2:0] f);
    case (f)
      3'b000:  return a == b;
      3'b001:  return a != b;
      3'b100:  return $signed(a) < $signed(b);
      3'b101:  return $signed(a) >= $signed(b);
      3'b110:  return $unsigned(a) < $unsigned(b);
      3'b111:  return $unsigned(a) >= $unsigned(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_ovf(logic [31:0] a, logic [31:0] b);
    logic [31:0] d = a - b;
    return (a[31] != b[31]) && (d[31] != a[31]);
  endfunction

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'b000, 3'b001: return "R1";
      3'b100:         return "R3";
      3'b101:         return "R5";
      3'b110, 3'b111: return "R4";
      default:        return "R8";
    endcase
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] f);
    logic [31:0] d;
    logic [32:0] wide;
    @(negedge clk);
    op_a = a; op_b = b; func = f; in_valid = 1'b1;
    @(posedge clk);
    #1;
    d = a - b;
    wide = {a[31], a} - {b[31], b};
    chk("R9", out_valid, 1'b1);
    chk(req_of(f), taken, ref_taken(a, b, f));
    chk("R8", illegal, (f == 3'b010 || f == 3'b011));
    chk("R1", flag_zero, a == b);
    chk("R2", eq_xor, a == b);
    chk("R4", flag_borrow, a < b);
    chk("R3", flag_sign, d[31]);
    chk("R3", flag_ovf, ref_ovf(a, b));
    chk("R6", flag_sign ^ flag_ovf, wide[32]);
    in_valid = 1'b0;
  endtask

  localparam logic [31:0] CORNER [5] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF};

  initial begin
    logic held;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R10", out_valid, 1'b0);
    chk("R10", taken, 1'b0);
    chk("R10", flag_zero | flag_borrow | flag_sign | flag_ovf | eq_xor | illegal, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    // R7: most negative against most positive
    apply(32'h8000_0000, 32'h7FFF_FFFF, 3'b100);
    chk("R7", taken, 1'b1);
    chk("R7", flag_sign, 1'b0);
    apply(32'd1, 32'd2, 3'b110);
    chk("R4", flag_borrow, 1'b1);

    for (int i = 0; i < 5; i++)
      for (int j = 0; j < 5; j++)
        for (int f = 0; f < 8; f++)
          apply(CORNER[i], CORNER[j], 3'(f));

    for (int n = 0; n < 2000; n++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom % 4 == 0) ? a : $urandom;
      apply(a, b, 3'($urandom));
    end

    // R9: idle cycle holds outputs
    apply(32'd5, 32'd5, 3'b000);
    held = taken;
    @(posedge clk);
    #1;
    chk("R9", out_valid, 1'b0);
    chk("R9", taken, held);

    // R10: mid-run reset
    apply(32'd3, 32'd9, 3'b110);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10", taken | out_valid | flag_borrow | flag_sign, 1'b0);
    rst = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule